// File: doc/BRIEF.md
# Multiplexed Seven-Segment and Indicator Scanner

This block drives a time-multiplexed LED readout made of twelve seven-segment numeric digits and eleven discrete indicator LEDs. The indicators are not wired separately: they are arranged as three extra scan positions that share the same eight-line segment bus. As a result, each indicator is a fixed segment at a fixed scan position. One 16-line, one-hot select bus picks the active position. Select line 0 is never driven.

The host presents twelve BCD digits, a decimal-point position, a blank-everything control, a leading-zero suppression enable and an 11-bit indicator word. The scanner copies all of these into a shadow register at the start of each scan frame, so one frame never mixes old and new values. Each position is lit for a programmable number of clock cycles. A short dark gap, with every select line and every segment low, follows each position to keep the previous digit from ghosting into the next one.

Top module: `led_scan_driver`

## Requirements
- R1: While reset is held, and for BLANK_CYCLES clock cycles after it is released, sel_o and seg_o are all zero.
- R2: The visible select line advances through 1, 2, ..., 15 and then wraps back to 1. Select line 0 is never active, and at most one select line is high at any time.
- R3: Each position is selected for exactly SCAN_DWELL consecutive cycles. It is followed by BLANK_CYCLES cycles in which sel_o and seg_o are both zero.
- R4: Numeric digit k (k = 0 is least significant, held in digits_i[4k+3:4k]) appears on select line k+1. seg_o uses bit 0 = a through bit 6 = g and bit 7 = decimal point, all active high, with the usual patterns: 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F.
- R5: A digit whose code is 10 to 15 shows no a–g segments.
- R6: When point_pos_i = k with k in 0..11, only digit k lights its decimal-point segment. Values 12 to 15 light no point.
- R7: With zero_sup_i high, a zero digit k > 0 is blanked when every more-significant digit is zero and k is above point_pos_i (or no point is set). Digit 0 is always shown.
- R8: blank_i high darkens all twelve numeric positions, including their points. Indicator positions are unaffected.
- R9: Indicator mapping, with bits of ind_i. Line 15: b=ind[0], c=ind[1], d=ind[2], e=ind[3]. Line 14: b=ind[4], c=ind[5], point=ind[6]. Line 13: b=ind[7], c=ind[8], d=ind[9], point=ind[10]. All other segments on these lines stay dark.
- R10: Inputs are captured only at the clock edge that moves the scan from line 15 to line 1. Changes at any other time have no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digits_i | input | 48 | Twelve BCD digits, digit 0 in bits 3:0 |
| point_pos_i | input | 4 | Digit index carrying the decimal point; 12–15 = none |
| zero_sup_i | input | 1 | Leading-zero suppression enable |
| blank_i | input | 1 | Darken all numeric digits |
| ind_i | input | 11 | Indicator LED states |
| seg_o | output | 8 | Segment bus, bit 0 = a … bit 6 = g, bit 7 = point |
| sel_o | output | 16 | One-hot scan position select |

## Verification
The bench targets leading-zero suppression at its edges: an all-zero readout must still show its last digit, a zero carrying the point must stay lit, and an invalid code in the top digit must stop suppression below it. A wrong rule here would either erase the whole readout or leave stray leading zeros. It also walks single indicator bits and their complement across the three pseudo-digits, so that a swapped bit or segment appears on the wrong line. It changes the inputs in the middle of a frame to catch a shadow that reloads too early, which would show a torn frame. It checks dwell and gap lengths and the 15-to-1 wrap, which an off-by-one counter or a scan that visits line 0 would break.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int DIGIT_COUNT  = 12;
    localparam int PSEUDO_COUNT = 3;
    localparam int IDX_W        = 4;
    localparam int SEL_W        = 2 ** IDX_W;
    localparam int SEG_W        = 8;
    localparam int IND_W        = 11;
    localparam int FIRST_POS    = 1;
    localparam int LAST_POS     = DIGIT_COUNT + PSEUDO_COUNT;

    // Pseudo-digit scan positions holding the indicator LEDs
    localparam int POS_IND_LO   = DIGIT_COUNT + 1;   // 13
    localparam int POS_IND_MID  = DIGIT_COUNT + 2;   // 14
    localparam int POS_IND_HI   = DIGIT_COUNT + 3;   // 15

    typedef struct packed {
        logic [DIGIT_COUNT*4-1:0] digits;
        logic [3:0]               point_pos;
        logic                     zero_sup;
        logic                     blank;
        logic [IND_W-1:0]         ind;
    } frame_t;

    // a..g in bits 0..6, active high; codes above 9 are dark
    function automatic logic [6:0] bcd_glyph(input logic [3:0] v);
        case (v)
            4'd0:    bcd_glyph = 7'h3F;
            4'd1:    bcd_glyph = 7'h06;
            4'd2:    bcd_glyph = 7'h5B;
            4'd3:    bcd_glyph = 7'h4F;
            4'd4:    bcd_glyph = 7'h66;
            4'd5:    bcd_glyph = 7'h6D;
            4'd6:    bcd_glyph = 7'h7D;
            4'd7:    bcd_glyph = 7'h07;
            4'd8:    bcd_glyph = 7'h7F;
            4'd9:    bcd_glyph = 7'h6F;
            default: bcd_glyph = 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import led_scan_pkg::*;
#(
    parameter int DWELL = 2000,
    parameter int BLANK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] idx_o,
    output logic             show_o,
    output logic             frame_start_o
);

    localparam int CNT_MAX = (DWELL > BLANK) ? DWELL : BLANK;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DWELL_END = CNT_W'(DWELL - 1);
    localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             show;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic frame_start_d;

    always_comb begin
        seq_d         = seq_q;
        frame_start_d = 1'b0;
        if (seq_q.show) begin
            if (seq_q.cnt == DWELL_END) begin
                seq_d.show = 1'b0;
                seq_d.cnt  = '0;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end else begin
            if (seq_q.cnt == BLANK_END) begin
                seq_d.cnt  = '0;
                seq_d.show = 1'b1;
                if (seq_q.idx == IDX_W'(LAST_POS)) begin
                    seq_d.idx     = IDX_W'(FIRST_POS);
                    frame_start_d = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.idx  <= IDX_W'(LAST_POS);
            seq_q.show <= 1'b0;
            seq_q.cnt  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idx_o         = seq_q.idx;
    assign show_o        = seq_q.show;
    assign frame_start_o = frame_start_d;

    // R2: decoder output 0 is never a scan position
    assert_idx_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_o != '0);

    // R10: a frame start is always followed by line 1 becoming visible
    assert_frame_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> (show_o && idx_o == IDX_W'(FIRST_POS)));

endmodule

// File: rtl/frame_shadow.sv
module frame_shadow
    import led_scan_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  frame_t frame_i,
    output frame_t frame_o
);

    frame_t held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (load_i) begin
            held_d = frame_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

    assign frame_o = held_q;

    // R10: the displayed frame only moves on a load
    assert_hold_between_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> frame_o == $past(frame_o));

endmodule

// File: rtl/segment_mapper.sv
module segment_mapper
    import led_scan_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  frame_t           frame_i,
    output logic [SEG_W-1:0] seg_o
);

    logic [3:0]             dig [DIGIT_COUNT];
    logic [DIGIT_COUNT-1:0] upper_zero;
    logic [SEG_W-1:0]       pat [SEL_W];
    logic                   point_valid;

    assign point_valid = frame_i.point_pos < 4'(DIGIT_COUNT);

    for (genvar k = 0; k < DIGIT_COUNT; k++) begin : g_dig_slice
        assign dig[k] = frame_i.digits[4*k +: 4];
    end

    // upper_zero[k]: every digit more significant than k is zero
    always_comb begin
        logic above;
        above = 1'b1;
        for (int k = DIGIT_COUNT - 1; k >= 0; k--) begin
            upper_zero[k] = above;
            above = above & (dig[k] == 4'd0);
        end
    end

    assign pat[0] = '0;

    for (genvar k = 0; k < DIGIT_COUNT; k++) begin : g_numeric
        logic point_here;
        logic point_guard;
        logic suppress;
        assign point_here  = !frame_i.blank && point_valid && (frame_i.point_pos == 4'(k));
        assign point_guard = point_valid && (4'(k) <= frame_i.point_pos);
        assign suppress    = frame_i.zero_sup && (k != 0) && (dig[k] == 4'd0)
                           && upper_zero[k] && !point_guard;
        assign pat[k+1]    = {point_here,
                              (frame_i.blank || suppress) ? 7'h00 : bcd_glyph(dig[k])};
    end

    // bit order: 7=point 6=g 5=f 4=e 3=d 2=c 1=b 0=a
    assign pat[POS_IND_LO]  = {frame_i.ind[10], 3'b000, frame_i.ind[9],
                               frame_i.ind[8], frame_i.ind[7], 1'b0};
    assign pat[POS_IND_MID] = {frame_i.ind[6], 4'b0000, frame_i.ind[5],
                               frame_i.ind[4], 1'b0};
    assign pat[POS_IND_HI]  = {3'b000, frame_i.ind[3], frame_i.ind[2],
                               frame_i.ind[1], frame_i.ind[0], 1'b0};

    assign seg_o = pat[idx_i];

endmodule

// File: rtl/led_scan_driver.sv
module led_scan_driver
    import led_scan_pkg::*;
#(
    parameter int SCAN_DWELL   = 2000,
    parameter int BLANK_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DIGIT_COUNT*4-1:0] digits_i,
    input  logic [3:0]               point_pos_i,
    input  logic                     zero_sup_i,
    input  logic                     blank_i,
    input  logic [IND_W-1:0]         ind_i,
    output logic [SEG_W-1:0]         seg_o,
    output logic [SEL_W-1:0]         sel_o
);

    localparam int RUN_W = $clog2(SCAN_DWELL + 1);

    logic [IDX_W-1:0] scan_idx;
    logic             show;
    logic             frame_start;
    frame_t           live_frame;
    frame_t           held_frame;
    logic [SEG_W-1:0] pattern;

    assign live_frame = '{digits:    digits_i,
                          point_pos: point_pos_i,
                          zero_sup:  zero_sup_i,
                          blank:     blank_i,
                          ind:       ind_i};

    scan_sequencer #(
        .DWELL (SCAN_DWELL),
        .BLANK (BLANK_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .idx_o         (scan_idx),
        .show_o        (show),
        .frame_start_o (frame_start)
    );

    frame_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (frame_start),
        .frame_i (live_frame),
        .frame_o (held_frame)
    );

    segment_mapper u_map (
        .idx_i   (scan_idx),
        .frame_i (held_frame),
        .seg_o   (pattern)
    );

    always_comb begin
        sel_o = show ? (SEL_W'(1) << scan_idx) : '0;
        seg_o = show ? pattern : '0;
    end

    // Checker state: last visible line and length of the current visible run
    typedef struct packed {
        logic [IDX_W-1:0] prev;
        logic [RUN_W-1:0] run;
    } chk_t;

    chk_t chk_d, chk_q;

    always_comb begin
        chk_d      = chk_q;
        chk_d.run  = show ? chk_q.run + 1'b1 : '0;
        if (show) begin
            chk_d.prev = scan_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_q.prev <= IDX_W'(LAST_POS);
            chk_q.run  <= '0;
        end else begin
            chk_q <= chk_d;
        end
    end

    assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    assert_line0_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_o[0]);

    assert_scan_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(show) |-> scan_idx == ((chk_q.prev == IDX_W'(LAST_POS)) ?
                                     IDX_W'(FIRST_POS) : chk_q.prev + 1'b1));

    assert_gap_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == '0) |-> (seg_o == '0));

    assert_dwell_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        show |-> chk_q.run < RUN_W'(SCAN_DWELL));

endmodule

// File: tb/led_scan_driver_test.sv
module led_scan_driver_test;
    import led_scan_pkg::*;

    localparam int DWELL    = 8;
    localparam int BLANK    = 2;
    localparam int WATCHDOG = 20000;

    typedef struct packed {
        logic [47:0]  dig;
        logic [3:0]   pt;
        logic         zs;
        logic         bl;
        logic [10:0]  ind;
        logic [119:0] exp;   // byte p-1 = expected seg_o on select line p
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{48'h123456789012, 4'd15, 1'b0, 1'b0, 11'h000,
          120'h000000065B4F666D7D077F6F3F065B},
        '{48'h000000000305, 4'd2,  1'b1, 1'b0, 11'h7FF,
          120'h1E868E000000000000000000CF3F6D},
        '{48'h888888888888, 4'd0,  1'b0, 1'b1, 11'h441,
          120'h028080000000000000000000000000},
        '{48'hFA0000000000, 4'd11, 1'b1, 1'b0, 11'h3BE,
          120'h1C060E80003F3F3F3F3F3F3F3F3F3F},
        '{48'h000000000000, 4'd15, 1'b1, 1'b0, 11'h000,
          120'h00000000000000000000000000003F},
        '{48'h000000700900, 4'd12, 1'b1, 1'b0, 11'h000,
          120'h000000000000000000073F3F6F3F3F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] digits = '0;
    logic [3:0]  point_pos = '0;
    logic        zero_sup = 1'b0;
    logic        blank = 1'b0;
    logic [10:0] ind = '0;
    logic [7:0]  seg;
    logic [15:0] sel;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    led_scan_driver #(
        .SCAN_DWELL   (DWELL),
        .BLANK_CYCLES (BLANK)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .digits_i    (digits),
        .point_pos_i (point_pos),
        .zero_sup_i  (zero_sup),
        .blank_i     (blank),
        .ind_i       (ind),
        .seg_o       (seg),
        .sel_o       (sel)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        digits    = v.dig;
        point_pos = v.pt;
        zero_sup  = v.zs;
        blank     = v.bl;
        ind       = v.ind;
    endtask

    task automatic wait_line(input int p);
        do @(negedge clk); while (sel !== (16'd1 << p));
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R4";
            1: return "R7";
            2: return "R8";
            3: return "R5";
            4: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic check_frame(input vec_t v, input string tag);
        wait_line(15);
        wait_line(1);
        for (int p = 1; p <= 15; p++) begin
            check("R2 select", sel, 16'd1 << p);
            check((p <= 12) ? tag : "R9", {8'h00, seg}, {8'h00, v.exp[8*(p-1) +: 8]});
            repeat (DWELL - 1) @(negedge clk);
            check("R3 dwell end", sel, 16'd1 << p);
            @(negedge clk);
            check("R3 gap", {sel[7:0] | sel[15:8], seg}, 16'h0000);
            repeat (BLANK) @(negedge clk);
        end
        check("R2 wrap to line 1", sel, 16'h0002);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        apply(VECS[0]);
        repeat (3) @(negedge clk);
        check("R1 sel in reset", sel, 16'h0000);
        check("R1 seg in reset", {8'h00, seg}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sel after release", sel, 16'h0000);
        check("R1 seg after release", {8'h00, seg}, 16'h0000);
        @(negedge clk);
        check("R2 first line", sel, 16'h0002);
        check("R4 first digit", {8'h00, seg}, 16'h005B);

        // Table walk
        for (int i = 0; i < 6; i++) begin
            apply(VECS[i]);
            check_frame(VECS[i], vec_tag(i));
        end

        // R10: mid-frame change does not tear the frame
        apply(VECS[0]);
        wait_line(15);
        wait_line(1);
        wait_line(6);
        apply(VECS[2]);
        wait_line(7);
        check("R10 line 7 held", {8'h00, seg}, 16'h007D);
        wait_line(13);
        check("R10 line 13 held", {8'h00, seg}, 16'h0000);
        wait_line(15);
        check("R10 line 15 held", {8'h00, seg}, 16'h0000);
        wait_line(1);
        check("R10 new frame line 1", {8'h00, seg}, 16'h0000);
        wait_line(15);
        check("R10 new frame line 15", {8'h00, seg}, 16'h0002);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule